// File: doc/BRIEF.md
# Congestion-Notified Rate Controller

This block is the sender-side rate adaptation engine for a single flow in a congestion-controlled fabric. It holds the flow's current transmit rate in Mbps and a congestion estimate, alpha. Alpha is an exponentially weighted moving average of how often congestion notifications arrive.

Each congestion notification strobe cuts the rate multiplicatively, by a fraction that grows with alpha. When alpha is near 1.0, a notification roughly halves the rate. Between notifications, a periodic recovery tick raises the rate by a programmable additive step and lets alpha decay. The rate never rises above the configured line rate and a cut never takes it below a configured floor.

The averaging gain is chosen from three power-of-two settings, so every alpha update is a shift and a subtraction. A pacer downstream reads the rate output. Software or a monitor reads alpha.

Top module: `cnp_rate_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the rate becomes the value on `lineRate` and alpha becomes 0xFFFF, which represents 1.0.
- R2: A cycle with `cnpIn` high sets the rate to `rate - ((rate * alpha) >> 17)`, using the alpha held before that cycle.
- R3: If the cut result of R2 is below `minRate`, the rate becomes `minRate` instead.
- R4: A cycle with `cnpIn` high sets alpha to `alpha - (alpha >> s) + (0xFFFF >> s)`.
- R5: The shift `s` comes from `gainSel`: 2'd2 gives s=1 (gain 0.5), 2'd1 gives s=2 (gain 0.25), and 2'd0 or 2'd3 gives s=3 (gain 0.125, the default).
- R6: A cycle with `tickIn` high and `cnpIn` low, when no notification has been seen since the previous accepted tick, adds `raiStep` to the rate and sets alpha to `alpha - (alpha >> s)`.
- R7: The increase of R6 is clamped to `lineRate`.
- R8: A tick with `cnpIn` low after one or more notifications since the previous tick changes neither the rate nor alpha. It clears the memory of those notifications, so the following tick raises the rate.
- R9: When `cnpIn` and `tickIn` are both high in one cycle, only the notification update of R2 to R4 applies. The tick is discarded and the notification counts as seen for R8.
- R10: In a cycle with neither strobe high, the rate and alpha hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnpIn | input | 1 | Congestion notification strobe, one per notification |
| tickIn | input | 1 | Recovery timer tick strobe |
| gainSel | input | 2 | Alpha gain select (see R5) |
| raiStep | input | 32 | Additive increase step in Mbps |
| lineRate | input | 32 | Maximum rate in Mbps, also the reset rate |
| minRate | input | 32 | Floor for a cut, in Mbps |
| rateOut | output | 32 | Current rate in Mbps |
| alphaOut | output | 16 | Congestion estimate, unsigned fraction with 0xFFFF as 1.0 |

## Verification
The hardest situations to reach are those where the hidden "notification seen" memory decides the outcome. These are a tick that arrives in the same cycle as a notification, and the first tick after one. The bench reaches both by raising both strobes in one cycle, then issuing single ticks and checking that the first one is absorbed and the second one raises the rate. The floor of R3 needs several back-to-back cuts with a high `minRate`. The ceiling of R7 needs ticks while the rate is already at line rate, which is the state right after reset.

// File: rtl/cnp_rate_pkg.sv
package cnp_rate_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic cut;    // apply the multiplicative decrease and alpha rise
    logic raise;  // apply the additive increase and alpha decay
  } rate_ctl_t;

  // Gain select to right-shift amount: 2 -> 1/2, 1 -> 1/4, 0 and 3 -> 1/8
  function automatic logic [2:0] gainShift(input logic [1:0] sel);
    case (sel)
      2'd1:    gainShift = 3'd2;
      2'd2:    gainShift = 3'd1;
      default: gainShift = 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/cnp_rate_ctrl_ctl.sv
module cnp_rate_ctrl_ctl
  import cnp_rate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cnpIn,
  input  logic      tickIn,
  output rate_ctl_t ctl
);

  logic seenQ;  // a notification arrived since the last accepted tick

  always_comb begin
    ctl.cut   = cnpIn;
    ctl.raise = tickIn && !cnpIn && !seenQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      seenQ <= 1'b0;
    else if (cnpIn)  seenQ <= 1'b1;
    else if (tickIn) seenQ <= 1'b0;
  end

endmodule

// File: rtl/cnp_rate_ctrl_dp.sv
module cnp_rate_ctrl_dp
  import cnp_rate_pkg::*;
#(
  parameter int RATE_W  = 32,
  parameter int ALPHA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rate_ctl_t          ctl,
  input  logic [1:0]         gainSel,
  input  logic [RATE_W-1:0]  raiStep,
  input  logic [RATE_W-1:0]  lineRate,
  input  logic [RATE_W-1:0]  minRate,
  output logic [RATE_W-1:0]  rateOut,
  output logic [ALPHA_W-1:0] alphaOut
);

  localparam int PROD_W = RATE_W + ALPHA_W;
  localparam logic [ALPHA_W-1:0] ALPHA_ONE = '1;

  logic [RATE_W-1:0]  rateQ;
  logic [ALPHA_W-1:0] alphaQ;

  logic [2:0]         shiftAmt;
  logic [PROD_W-1:0]  prod;
  logic [RATE_W-1:0]  cutAmt, cutRate, cutClamped;
  logic [RATE_W:0]    sumRate;
  logic [RATE_W-1:0]  raisedRate;
  logic [ALPHA_W-1:0] alphaKeep;
  logic [ALPHA_W:0]   alphaSum;
  logic [ALPHA_W-1:0] alphaRise;

  always_comb begin
    shiftAmt   = gainShift(gainSel);
    // multiplicative decrease by alpha/2
    prod       = {{ALPHA_W{1'b0}}, rateQ} * {{RATE_W{1'b0}}, alphaQ};
    cutAmt     = RATE_W'(prod >> (ALPHA_W + 1));
    cutRate    = rateQ - cutAmt;
    cutClamped = (cutRate < minRate) ? minRate : cutRate;
    // additive increase, saturating at line rate
    sumRate    = {1'b0, rateQ} + {1'b0, raiStep};
    raisedRate = (sumRate > {1'b0, lineRate}) ? lineRate : sumRate[RATE_W-1:0];
    // alpha EWMA with power-of-two gain
    alphaKeep  = alphaQ - (alphaQ >> shiftAmt);
    alphaSum   = {1'b0, alphaKeep} + {1'b0, (ALPHA_ONE >> shiftAmt)};
    alphaRise  = alphaSum[ALPHA_W] ? ALPHA_ONE : alphaSum[ALPHA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rateQ  <= lineRate;
      alphaQ <= ALPHA_ONE;
    end else if (ctl.cut) begin
      rateQ  <= cutClamped;
      alphaQ <= alphaRise;
    end else if (ctl.raise) begin
      rateQ  <= raisedRate;
      alphaQ <= alphaKeep;
    end
  end

  assign rateOut  = rateQ;
  assign alphaOut = alphaQ;

endmodule

// File: rtl/cnp_rate_ctrl.sv
module cnp_rate_ctrl
  import cnp_rate_pkg::*;
#(
  parameter int RATE_W  = 32,
  parameter int ALPHA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnpIn,
  input  logic               tickIn,
  input  logic [1:0]         gainSel,
  input  logic [RATE_W-1:0]  raiStep,
  input  logic [RATE_W-1:0]  lineRate,
  input  logic [RATE_W-1:0]  minRate,
  output logic [RATE_W-1:0]  rateOut,
  output logic [ALPHA_W-1:0] alphaOut
);

  rate_ctl_t ctl;

  cnp_rate_ctrl_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnpIn  (cnpIn),
    .tickIn (tickIn),
    .ctl    (ctl)
  );

  cnp_rate_ctrl_dp #(.RATE_W(RATE_W), .ALPHA_W(ALPHA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .gainSel  (gainSel),
    .raiStep  (raiStep),
    .lineRate (lineRate),
    .minRate  (minRate),
    .rateOut  (rateOut),
    .alphaOut (alphaOut)
  );

endmodule

// File: rtl/cnp_rate_ctrl_chk.sv
module cnp_rate_ctrl_chk #(
  parameter int RATE_W  = 32,
  parameter int ALPHA_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cnpIn,
  input logic               tickIn,
  input logic [RATE_W-1:0]  lineRate,
  input logic [RATE_W-1:0]  minRate,
  input logic [RATE_W-1:0]  rateOut,
  input logic [ALPHA_W-1:0] alphaOut
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (rateOut == $past(lineRate)) && (&alphaOut));

  // R2
  cut_not_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnpIn && rateOut >= minRate) |=> rateOut <= $past(rateOut));

  // R3
  cut_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnpIn |=> rateOut >= $past(minRate));

  // R4
  alpha_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnpIn |=> alphaOut >= $past(alphaOut));

  // R6
  alpha_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tickIn && !cnpIn) |=> alphaOut <= $past(alphaOut));

  // R7
  raise_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tickIn && !cnpIn) |=> (rateOut <= $past(lineRate)) || (rateOut == $past(rateOut)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickIn && !cnpIn) |=> $stable(rateOut) && $stable(alphaOut));

endmodule

bind cnp_rate_ctrl cnp_rate_ctrl_chk #(.RATE_W(RATE_W), .ALPHA_W(ALPHA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnpIn    (cnpIn),
  .tickIn   (tickIn),
  .lineRate (lineRate),
  .minRate  (minRate),
  .rateOut  (rateOut),
  .alphaOut (alphaOut)
);

// File: tb/cnp_rate_ctrl_bench.sv
module cnp_rate_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnpIn = 1'b0;
  logic        tickIn = 1'b0;
  logic [1:0]  gainSel = 2'd0;
  logic [31:0] raiStep = 32'd100;
  logic [31:0] lineRate = 32'd100000;
  logic [31:0] minRate = 32'd1000;
  logic [31:0] rateOut;
  logic [15:0] alphaOut;

  int testCount = 0;
  int failCount = 0;

  // bench model of the requirements
  longint mRate;
  longint mAlpha;
  bit     mSeen;

  always #4 clk = ~clk;  // 125 MHz

  cnp_rate_ctrl u_cnp_rate_ctrl (
    .clk(clk), .rst_n(rst_n), .cnpIn(cnpIn), .tickIn(tickIn), .gainSel(gainSel),
    .raiStep(raiStep), .lineRate(lineRate), .minRate(minRate),
    .rateOut(rateOut), .alphaOut(alphaOut)
  );

  function automatic int shiftOf(input logic [1:0] sel);
    // R5 encoding
    if (sel == 2'd2) return 1;
    if (sel == 2'd1) return 2;
    return 3;
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; cnpIn = 1'b0; tickIn = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    mRate = lineRate; mAlpha = 65535; mSeen = 0;
    check("R1", "rate", rateOut, mRate);
    check("R1", "alpha", alphaOut, mAlpha);
    rst_n = 1'b1;
  endtask

  // one cycle with the given strobes, then check both outputs
  task automatic step(input bit cnp, input bit tick, input string rTag, input string aTag);
    int s;
    longint nr;
    s = shiftOf(gainSel);
    cnpIn = cnp; tickIn = tick;
    @(posedge clk); @(negedge clk);
    cnpIn = 1'b0; tickIn = 1'b0;
    if (cnp) begin
      nr = mRate - ((mRate * mAlpha) >> 17);
      if (nr < minRate) nr = minRate;
      mRate = nr;
      mAlpha = mAlpha - (mAlpha >> s) + (65535 >> s);
      mSeen = 1;
    end else if (tick) begin
      if (mSeen) mSeen = 0;
      else begin
        nr = mRate + raiStep;
        if (nr > lineRate) nr = lineRate;
        mRate = nr;
        mAlpha = mAlpha - (mAlpha >> s);
      end
    end
    check(rTag, "rate", rateOut, mRate);
    check(aTag, "alpha", alphaOut, mAlpha);
  endtask

  initial begin
    #(8 * 150000);
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int g = 0; g < 4; g++) begin
      gainSel = 2'(g);
      raiStep = (g % 2 == 0) ? 32'd100 : 32'd50;
      minRate = 32'd1000;
      doReset();
      // R7: ticks at line rate stay at the ceiling, R6 alpha decays
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R7", "R6");
      // R2 / R4 / R5: chain of cuts
      for (int i = 0; i < 12; i++) step(1'b1, 1'b0, "R2", "R5");
      // R8: first tick after cuts is absorbed
      step(1'b0, 1'b1, "R8", "R8");
      // R6: recovery
      for (int i = 0; i < 30; i++) step(1'b0, 1'b1, "R6", "R6");
      // R9: simultaneous strobes, notification wins
      step(1'b1, 1'b1, "R9", "R9");
      step(1'b0, 1'b1, "R8", "R9");
      step(1'b0, 1'b1, "R6", "R6");
      // R4 with interleaved pattern
      for (int i = 0; i < 6; i++) begin
        step(1'b1, 1'b0, "R2", "R4");
        step(1'b0, 1'b1, "R8", "R8");
        step(1'b0, 1'b1, "R6", "R6");
      end
      // R10: idle cycles hold
      step(1'b0, 1'b0, "R10", "R10");
      step(1'b0, 1'b0, "R10", "R10");
      // R3: floor at a high minimum rate
      minRate = 32'd60000;
      doReset();
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R3", "R4");
      step(1'b0, 1'b0, "R10", "R10");
    end
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule